// File: doc/BRIEF.md
# Output Emergency Shutdown Controller

This block drives the high-impedance controls of two groups of power-driver pins: a main high-current group and a separate channel-0 group. Up to nine active-low fault inputs are watched. Each input is either edge-triggered or level-qualified. A level-qualified input must read low on sixteen consecutive samples taken at a prescaled rate. A second detector watches complementary driver output pairs and trips when both sides of an enabled pair sit at the pair's active level on one clock edge. Every trip is held in a sticky flag. That flag keeps its pin group released until software reads it and then writes zero to it. Software can also force either group off directly. An interrupt line collects the enabled fault flags and, behind a single enable, the pair flags.

Each fault input runs a small state machine with three states: `DET_WATCH`, `DET_COUNT` and `DET_TRIP`. The transitions work as follows:
- From `DET_WATCH`, a falling edge in edge mode goes straight to `DET_TRIP`. In a sampling mode, a low sample goes to `DET_COUNT` with the count at one.
- In `DET_COUNT`, a high sample returns to `DET_WATCH` and zeroes the count. The sixteenth consecutive low sample moves to `DET_TRIP`. A switch back to edge mode also returns to `DET_WATCH`.
- `DET_TRIP` returns to `DET_WATCH` only on an armed software clear, and never while a sampling-mode input still reads low.

Inputs pass a two-flop synchronizer before detection. A free-running 7-bit prescaler supplies sample strobes on every 8th, 16th and 128th clock.

Top module: `outshut_ctrl`

## Requirements
- R1: After reset every register reads zero: all inputs are in edge mode (code 0), all interrupt enables and force bits are off, all flags are clear, and `hiz_main`, `hiz_ch0` and `irq` are low.
- R2: In mode code 0 (register 0, bits [2i+1:2i]), a high-to-low transition on `fault_n[i]` sets flag i (register 1, bit i). The flag reaches the outputs no later than the fourth clock edge after the pin falls.
- R3: Mode codes 1, 2 and 3 sample the synchronized input once every 8, 16 or 128 clocks. Flag i sets only after sixteen consecutive low samples.
- R4: In a sampling mode, any high sample restarts the count of low samples from zero.
- R5: A set input flag drives its group's output only when its shutdown enable (register 3, bit i) is one. Group select (register 3, bit 16+i) chooses `hiz_ch0` when one and `hiz_main` when zero.
- R6: An enabled pair j (register 4, bit j) whose `drv_hi[j]` and `drv_lo[j]` both equal its active level (register 4, bit 8+j: one means active high) on a clock edge sets pair flag j (register 4, bit 16+j) on that edge. The pair flag drives `hiz_main`.
- R7: A pair whose enable bit is zero never sets its flag, whatever its outputs do.
- R8: Force bits in register 2 hold the groups released directly: bit 17 drives `hiz_main` and bit 18 drives `hiz_ch0`.
- R9: `irq` is the OR of each input flag gated by its enable (register 2, bit i), plus the OR of the pair flags gated by register 2, bit 16.
- R10: A flag clears only when zero is written to its bit after a read of its register returned it as one. Writing zero without such a read leaves it set.
- R11: In a sampling mode, an armed clear is ignored while the synchronized input still reads low. A pair flag is not cleared on an edge where its pair is still in conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW (3) | Register address: 0 modes, 1 input flags, 2 control, 3 routing, 4 pairs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when `reg_rd` is low |
| fault_n | input | N_IN (9) | Active-low fault inputs |
| drv_hi | input | N_PAIR (3) | High-side driver level of each pair |
| drv_lo | input | N_PAIR (3) | Low-side driver level of each pair |
| hiz_main | output | 1 | High-impedance control of the main pin group |
| hiz_ch0 | output | 1 | High-impedance control of the channel-0 pin group |
| irq | output | 1 | Interrupt request |

## Verification
The input detectors and the pair comparators share `hiz_main` and run in parallel. The bench therefore drops two sampling-mode inputs at once, one at each of the two prescaled rates and each routed to its own group, so that the faster trip reaches `hiz_main` while the slower count is still building. It later pulses two pair conflicts, of opposite active level, on consecutive edges. A behavioural reference model, driven with the same stimulus, predicts both group outputs, the interrupt and every read word on each clock. The checks then confirm that neither path masks or releases the other.

// File: rtl/outshut_pkg.sv
package outshut_pkg;
    typedef enum logic [1:0] {
        DET_WATCH = 2'd0,
        DET_COUNT = 2'd1,
        DET_TRIP  = 2'd2
    } det_state_e;

    localparam logic [1:0] MD_EDGE   = 2'd0;
    localparam logic [1:0] MD_DIV8   = 2'd1;
    localparam logic [1:0] MD_DIV16  = 2'd2;
    localparam logic [1:0] MD_DIV128 = 2'd3;

    localparam int A_MODE  = 0;
    localparam int A_FLAG  = 1;
    localparam int A_CTRL  = 2;
    localparam int A_ROUTE = 3;
    localparam int A_PAIR  = 4;

    localparam int GRP_OFS    = 16;
    localparam int ACT_OFS    = 8;
    localparam int PFLAG_OFS  = 16;
    localparam int CMPIRQ_BIT = 16;
    localparam int FRCM_BIT   = 17;
    localparam int FRCC_BIT   = 18;
endpackage

// File: rtl/outshut_fault_det.sv
module outshut_fault_det
    import outshut_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_n,
    input  logic [1:0] mode,
    input  logic       tick8,
    input  logic       tick16,
    input  logic       tick128,
    input  logic       clr_req,
    output logic       trip
);
    localparam logic [CNT_W-1:0] LAST = '1;

    logic s1, s2, s3;
    logic fall, tick, lvl_mode;
    det_state_e st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    // two-flop synchronizer plus one history stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= pin_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    always_comb begin
        fall     = s3 && !s2;
        lvl_mode = (mode != MD_EDGE);
        case (mode)
            MD_DIV8:   tick = tick8;
            MD_DIV16:  tick = tick16;
            MD_DIV128: tick = tick128;
            default:   tick = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= DET_WATCH;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // next state and outputs
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            DET_WATCH: begin
                if (!lvl_mode) begin
                    if (fall) st_nx = DET_TRIP;
                end else if (tick && !s2) begin
                    st_nx  = DET_COUNT;
                    cnt_nx = CNT_W'(1);
                end
            end
            DET_COUNT: begin
                if (!lvl_mode) begin
                    st_nx  = DET_WATCH;
                    cnt_nx = '0;
                end else if (tick) begin
                    if (s2) begin
                        st_nx  = DET_WATCH;
                        cnt_nx = '0;
                    end else if (cnt == LAST) begin
                        st_nx = DET_TRIP;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            DET_TRIP: begin
                if (clr_req && !(lvl_mode && !s2)) begin
                    st_nx  = DET_WATCH;
                    cnt_nx = '0;
                end
            end
            default: begin
                st_nx  = DET_WATCH;
                cnt_nx = '0;
            end
        endcase
        trip = (st == DET_TRIP);
    end
endmodule

// File: rtl/outshut_pair_cmp.sv
module outshut_pair_cmp (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_a,
    input  logic drv_b,
    input  logic en,
    input  logic act_hi,
    input  logic clr_req,
    output logic flag
);
    logic clash;

    always_comb clash = en && (drv_a == act_hi) && (drv_b == act_hi);

    // a conflict on the same edge outranks a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag <= 1'b0;
        else if (clash)   flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end
endmodule

// File: rtl/outshut_ctrl.sv
module outshut_ctrl
    import outshut_pkg::*;
#(
    parameter int N_IN   = 9,
    parameter int N_PAIR = 3,
    parameter int AW     = 3,
    parameter int DW     = 32,
    parameter int PRE_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [N_IN-1:0]   fault_n,
    input  logic [N_PAIR-1:0] drv_hi,
    input  logic [N_PAIR-1:0] drv_lo,
    output logic              hiz_main,
    output logic              hiz_ch0,
    output logic              irq
);
    localparam int MODE_W = 2 * N_IN;
    localparam int T8_W   = 3;
    localparam int T16_W  = 4;

    logic [MODE_W-1:0] mode_q;
    logic [N_IN-1:0]   irq_en_q, hiz_en_q, grp_ch0_q;
    logic              cmp_irq_en_q, frc_main_q, frc_ch0_q;
    logic [N_PAIR-1:0] cmp_en_q, act_hi_q;
    logic [N_IN-1:0]   in_trip, in_arm, in_clr;
    logic [N_PAIR-1:0] cmp_flag, cmp_arm, cmp_clr;
    logic [PRE_W-1:0]  pres_q;
    logic              tick8, tick16, tick128;
    logic              wr_flag, wr_pair, rd_flag, rd_pair;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pres_q <= '0;
        else        pres_q <= pres_q + 1'b1;
    end

    always_comb begin
        tick8   = &pres_q[T8_W-1:0];
        tick16  = &pres_q[T16_W-1:0];
        tick128 = &pres_q;
        wr_flag = reg_wr && (reg_addr == AW'(A_FLAG));
        wr_pair = reg_wr && (reg_addr == AW'(A_PAIR));
        rd_flag = reg_rd && (reg_addr == AW'(A_FLAG));
        rd_pair = reg_rd && (reg_addr == AW'(A_PAIR));
        in_clr  = {N_IN{wr_flag}} & ~reg_wdata[N_IN-1:0] & in_arm;
        cmp_clr = {N_PAIR{wr_pair}} & ~reg_wdata[PFLAG_OFS +: N_PAIR] & cmp_arm;
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        outshut_fault_det u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_n   (fault_n[i]),
            .mode    (mode_q[2*i +: 2]),
            .tick8   (tick8),
            .tick16  (tick16),
            .tick128 (tick128),
            .clr_req (in_clr[i]),
            .trip    (in_trip[i])
        );
    end

    for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
        outshut_pair_cmp u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .drv_a   (drv_hi[j]),
            .drv_b   (drv_lo[j]),
            .en      (cmp_en_q[j]),
            .act_hi  (act_hi_q[j]),
            .clr_req (cmp_clr[j]),
            .flag    (cmp_flag[j])
        );
    end

    // a read that returns a set flag arms its clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_arm  <= '0;
            cmp_arm <= '0;
        end else begin
            in_arm  <= in_trip & (in_arm | {N_IN{rd_flag}});
            cmp_arm <= cmp_flag & (cmp_arm | {N_PAIR{rd_pair}});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q       <= '0;
            irq_en_q     <= '0;
            cmp_irq_en_q <= 1'b0;
            frc_main_q   <= 1'b0;
            frc_ch0_q    <= 1'b0;
            hiz_en_q     <= '0;
            grp_ch0_q    <= '0;
            cmp_en_q     <= '0;
            act_hi_q     <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                AW'(A_MODE): mode_q <= reg_wdata[MODE_W-1:0];
                AW'(A_CTRL): begin
                    irq_en_q     <= reg_wdata[N_IN-1:0];
                    cmp_irq_en_q <= reg_wdata[CMPIRQ_BIT];
                    frc_main_q   <= reg_wdata[FRCM_BIT];
                    frc_ch0_q    <= reg_wdata[FRCC_BIT];
                end
                AW'(A_ROUTE): begin
                    hiz_en_q  <= reg_wdata[N_IN-1:0];
                    grp_ch0_q <= reg_wdata[GRP_OFS +: N_IN];
                end
                AW'(A_PAIR): begin
                    cmp_en_q <= reg_wdata[N_PAIR-1:0];
                    act_hi_q <= reg_wdata[ACT_OFS +: N_PAIR];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                AW'(A_MODE): reg_rdata[MODE_W-1:0] = mode_q;
                AW'(A_FLAG): reg_rdata[N_IN-1:0]   = in_trip;
                AW'(A_CTRL): begin
                    reg_rdata[N_IN-1:0]   = irq_en_q;
                    reg_rdata[CMPIRQ_BIT] = cmp_irq_en_q;
                    reg_rdata[FRCM_BIT]   = frc_main_q;
                    reg_rdata[FRCC_BIT]   = frc_ch0_q;
                end
                AW'(A_ROUTE): begin
                    reg_rdata[N_IN-1:0]        = hiz_en_q;
                    reg_rdata[GRP_OFS +: N_IN] = grp_ch0_q;
                end
                AW'(A_PAIR): begin
                    reg_rdata[N_PAIR-1:0]          = cmp_en_q;
                    reg_rdata[ACT_OFS +: N_PAIR]   = act_hi_q;
                    reg_rdata[PFLAG_OFS +: N_PAIR] = cmp_flag;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        hiz_main = (|(in_trip & hiz_en_q & ~grp_ch0_q)) || (|cmp_flag) || frc_main_q;
        hiz_ch0  = (|(in_trip & hiz_en_q & grp_ch0_q)) || frc_ch0_q;
        irq      = (|(in_trip & irq_en_q)) || (cmp_irq_en_q && (|cmp_flag));
    end
endmodule

// File: rtl/outshut_chk.sv
module outshut_chk
    import outshut_pkg::*;
#(
    parameter int N_IN   = 9,
    parameter int N_PAIR = 3,
    parameter int AW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     reg_addr,
    input logic              reg_wr,
    input logic [N_PAIR-1:0] drv_hi,
    input logic [N_PAIR-1:0] drv_lo,
    input logic [N_PAIR-1:0] cmp_en,
    input logic [N_PAIR-1:0] act_hi,
    input logic [N_PAIR-1:0] cmp_flag,
    input logic [N_IN-1:0]   in_trip,
    input logic              frc_main,
    input logic              frc_ch0,
    input logic              hiz_main,
    input logic              hiz_ch0,
    input logic              irq
);
    for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
        // R6: a conflict on an enabled pair is flagged on the next edge
        assert_pair_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_en[j] && drv_hi[j] == act_hi[j] && drv_lo[j] == act_hi[j]) |=> cmp_flag[j]);
        // R7: a disabled pair keeps a clear flag clear
        assert_pair_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!cmp_en[j] && !cmp_flag[j]) |=> !cmp_flag[j]);
    end

    assert_pair_shut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmp_flag) |-> hiz_main);

    assert_force_main_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frc_main |-> hiz_main);

    assert_force_ch0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frc_ch0 |-> hiz_ch0);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((|in_trip) || (|cmp_flag)));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(in_trip) & ~in_trip)) |-> $past(reg_wr && reg_addr == AW'(A_FLAG)));

    assert_pair_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(cmp_flag) & ~cmp_flag)) |-> $past(reg_wr && reg_addr == AW'(A_PAIR)));
endmodule

bind outshut_ctrl outshut_chk #(
    .N_IN   (N_IN),
    .N_PAIR (N_PAIR),
    .AW     (AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .drv_hi   (drv_hi),
    .drv_lo   (drv_lo),
    .cmp_en   (cmp_en_q),
    .act_hi   (act_hi_q),
    .cmp_flag (cmp_flag),
    .in_trip  (in_trip),
    .frc_main (frc_main_q),
    .frc_ch0  (frc_ch0_q),
    .hiz_main (hiz_main),
    .hiz_ch0  (hiz_ch0),
    .irq      (irq)
);

// File: tb/outshut_ctrl_tb.sv
`timescale 1ns/1ps
module outshut_ctrl_tb;
    localparam int N = 9;
    localparam int P = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] fault_n = '1;
    logic [P-1:0] drv_hi = 3'b010;
    logic [P-1:0] drv_lo = 3'b010;
    logic        hiz_main, hiz_ch0, irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    outshut_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fault_n(fault_n), .drv_hi(drv_hi), .drv_lo(drv_lo),
        .hiz_main(hiz_main), .hiz_ch0(hiz_ch0), .irq(irq)
    );

    // behavioural reference model
    int m_pres;
    bit m_s1[N], m_s2[N], m_s3[N], m_arm[N];
    int m_st[N], m_cnt[N], m_mode[N];
    bit m_irqen[N], m_hizen[N], m_grp[N];
    bit m_cirq, m_fm, m_fc;
    bit m_cen[P], m_act[P], m_cflag[P], m_carm[P];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pres = 0; m_cirq = 0; m_fm = 0; m_fc = 0;
            for (int i = 0; i < N; i++) begin
                m_s1[i] = 1; m_s2[i] = 1; m_s3[i] = 1; m_arm[i] = 0;
                m_st[i] = 0; m_cnt[i] = 0; m_mode[i] = 0;
                m_irqen[i] = 0; m_hizen[i] = 0; m_grp[i] = 0;
            end
            for (int j = 0; j < P; j++) begin
                m_cen[j] = 0; m_act[j] = 0; m_cflag[j] = 0; m_carm[j] = 0;
            end
        end else begin
            bit t8, t16, t128;
            t8 = (m_pres % 8) == 7;
            t16 = (m_pres % 16) == 15;
            t128 = m_pres == 127;
            m_pres = (m_pres + 1) % 128;
            for (int i = 0; i < N; i++) begin
                bit fall, lvl, tk, clr;
                int nst, ncnt;
                fall = m_s3[i] && !m_s2[i];
                lvl = m_mode[i] != 0;
                tk = (m_mode[i] == 1) ? t8 : (m_mode[i] == 2) ? t16 : (m_mode[i] == 3) ? t128 : 1'b0;
                clr = reg_wr && reg_addr == 1 && !reg_wdata[i] && m_arm[i];
                nst = m_st[i]; ncnt = m_cnt[i];
                if (m_st[i] == 0) begin
                    if (!lvl) begin if (fall) nst = 2; end
                    else if (tk && !m_s2[i]) begin nst = 1; ncnt = 1; end
                end else if (m_st[i] == 1) begin
                    if (!lvl) begin nst = 0; ncnt = 0; end
                    else if (tk) begin
                        if (m_s2[i]) begin nst = 0; ncnt = 0; end
                        else if (m_cnt[i] >= 15) nst = 2;
                        else ncnt = m_cnt[i] + 1;
                    end
                end else if (clr && !(lvl && !m_s2[i])) begin
                    nst = 0; ncnt = 0;
                end
                if (m_st[i] != 2) m_arm[i] = 0;
                else if (reg_rd && reg_addr == 1) m_arm[i] = 1;
                m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = fault_n[i];
                m_st[i] = nst; m_cnt[i] = ncnt;
            end
            for (int j = 0; j < P; j++) begin
                bit both, clr;
                both = m_cen[j] && drv_hi[j] == m_act[j] && drv_lo[j] == m_act[j];
                clr = reg_wr && reg_addr == 4 && !reg_wdata[16+j] && m_carm[j];
                if (!m_cflag[j]) m_carm[j] = 0;
                else if (reg_rd && reg_addr == 4) m_carm[j] = 1;
                if (both) m_cflag[j] = 1;
                else if (clr) m_cflag[j] = 0;
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: for (int i = 0; i < N; i++) m_mode[i] = reg_wdata[2*i +: 2];
                    3'd2: begin
                        for (int i = 0; i < N; i++) m_irqen[i] = reg_wdata[i];
                        m_cirq = reg_wdata[16]; m_fm = reg_wdata[17]; m_fc = reg_wdata[18];
                    end
                    3'd3: for (int i = 0; i < N; i++) begin
                        m_hizen[i] = reg_wdata[i]; m_grp[i] = reg_wdata[16+i];
                    end
                    3'd4: for (int j = 0; j < P; j++) begin
                        m_cen[j] = reg_wdata[j]; m_act[j] = reg_wdata[8+j];
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_main, e_ch0, e_irq, anyc;
            logic [31:0] e_rd;
            e_main = m_fm; e_ch0 = m_fc; e_irq = 0; anyc = 0; e_rd = '0;
            for (int j = 0; j < P; j++) anyc |= m_cflag[j];
            for (int i = 0; i < N; i++) begin
                if (m_st[i] == 2 && m_hizen[i] && !m_grp[i]) e_main = 1;
                if (m_st[i] == 2 && m_hizen[i] && m_grp[i]) e_ch0 = 1;
                if (m_st[i] == 2 && m_irqen[i]) e_irq = 1;
            end
            e_main |= anyc;
            e_irq |= m_cirq && anyc;
            if (reg_rd) begin
                case (reg_addr)
                    3'd0: for (int i = 0; i < N; i++) e_rd[2*i +: 2] = 2'(m_mode[i]);
                    3'd1: for (int i = 0; i < N; i++) e_rd[i] = (m_st[i] == 2);
                    3'd2: begin
                        for (int i = 0; i < N; i++) e_rd[i] = m_irqen[i];
                        e_rd[16] = m_cirq; e_rd[17] = m_fm; e_rd[18] = m_fc;
                    end
                    3'd3: for (int i = 0; i < N; i++) begin
                        e_rd[i] = m_hizen[i]; e_rd[16+i] = m_grp[i];
                    end
                    3'd4: for (int j = 0; j < P; j++) begin
                        e_rd[j] = m_cen[j]; e_rd[8+j] = m_act[j]; e_rd[16+j] = m_cflag[j];
                    end
                    default: ;
                endcase
            end
            checks++;
            if ({hiz_main, hiz_ch0, irq} !== {e_main, e_ch0, e_irq} || reg_rdata !== e_rd) begin
                fails++;
                $display("FAIL %s model: got main/ch0/irq=%b%b%b rdata=%h expected %b%b%b rdata=%h",
                         phase, hiz_main, hiz_ch0, irq, reg_rdata, e_main, e_ch0, e_irq, e_rd);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = 3'(a); reg_rd = 1'b1;
        @(negedge clk); d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pin(input int i, input logic v);
        @(posedge clk); #1;
        fault_n[i] = v;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        phase = "R1";
        wait_clk(2);
        chk("R1 outputs", {29'd0, hiz_main, hiz_ch0, irq}, 32'd0);
        rd(0, d); chk("R1 mode", d, 32'd0);
        rd(2, d); chk("R1 ctrl", d, 32'd0);
        rd(1, d); chk("R1 flags", d, 32'd0);

        // R2 edge trip on input 0, main group, irq enabled
        phase = "R2";
        wr(2, 32'h1);
        wr(3, 32'h1);
        pin(0, 0); wait_clk(3); pin(0, 1);
        wait_clk(6);
        chk("R2 hiz_main", {31'd0, hiz_main}, 32'd1);
        chk("R2 hiz_ch0", {31'd0, hiz_ch0}, 32'd0);
        chk("R2 irq", {31'd0, irq}, 32'd1);

        // R10 clear needs a prior read
        phase = "R10";
        wr(1, 32'h0);
        wait_clk(1);
        chk("R10 unarmed write ignored", {31'd0, hiz_main}, 32'd1);
        rd(1, d); chk("R2 flag bit 0", d, 32'h1);
        wr(1, 32'h0);
        wait_clk(1);
        chk("R10 armed clear", {31'd0, hiz_main}, 32'd0);
        rd(1, d); chk("R10 flags after clear", d, 32'h0);

        // R5 routing to channel-0 group and shutdown enable mask
        phase = "R5";
        wr(3, 32'h0002_0003);
        pin(1, 0); wait_clk(3); pin(1, 1);
        wait_clk(6);
        chk("R5 ch0 group", {30'd0, hiz_main, hiz_ch0}, 32'b01);
        rd(1, d); wr(1, 32'h0);
        pin(5, 0); wait_clk(3); pin(5, 1);
        wait_clk(6);
        chk("R5 masked input", {30'd0, hiz_main, hiz_ch0}, 32'b00);
        rd(1, d); chk("R5 masked flag still set", d, 32'h20);
        wr(1, 32'h0);

        // R3 two sampling rates in parallel, to different groups
        phase = "R3";
        wr(0, 32'h0000_00D0);
        wr(3, 32'h0008_000C);
        @(posedge clk); #1 fault_n[2] = 0; fault_n[3] = 0;
        wait_clk(100);
        chk("R3 div8 not yet", {31'd0, hiz_main}, 32'd0);
        wait_clk(60);
        chk("R3 div8 tripped", {30'd0, hiz_main, hiz_ch0}, 32'b10);
        wait_clk(1640);
        chk("R3 div128 not yet", {31'd0, hiz_ch0}, 32'd0);
        wait_clk(500);
        chk("R3 div128 tripped", {31'd0, hiz_ch0}, 32'd1);
        @(posedge clk); #1 fault_n[2] = 1; fault_n[3] = 1;
        wait_clk(5);
        rd(1, d); chk("R3 flags", d, 32'h0C);
        wr(1, 32'h0);
        rd(1, d); chk("R3 flags cleared", d, 32'h0);

        // R4 high sample restarts the count
        phase = "R4";
        wr(0, 32'h0000_02D0);
        wr(3, 32'h0008_001C);
        pin(4, 0); wait_clk(120);
        pin(4, 1); wait_clk(40);
        pin(4, 0); wait_clk(120);
        chk("R4 restart", {31'd0, hiz_main}, 32'd0);
        wait_clk(200);
        chk("R4 trip", {31'd0, hiz_main}, 32'd1);

        // R11 clear blocked while low
        phase = "R11";
        rd(1, d); chk("R11 flag", d, 32'h10);
        wr(1, 32'h0);
        wait_clk(1);
        chk("R11 blocked", {31'd0, hiz_main}, 32'd1);
        pin(4, 1); wait_clk(5);
        wr(1, 32'h0);
        wait_clk(1);
        chk("R11 released", {31'd0, hiz_main}, 32'd0);

        // R7 disabled pair and single-sided activity
        phase = "R7";
        wr(4, 32'h0000_0103);
        @(posedge clk); #1 drv_hi = 3'b110; drv_lo = 3'b110;
        wait_clk(3);
        @(posedge clk); #1 drv_hi = 3'b111;
        wait_clk(3);
        rd(4, d); chk("R7 no pair flag", d, 32'h0000_0103);

        // R6 conflicts on consecutive edges, opposite polarities
        phase = "R6";
        @(posedge clk); #1 drv_lo = 3'b111;
        @(posedge clk); #1 drv_hi = 3'b101; drv_lo = 3'b100;
        @(posedge clk); #1 drv_hi = 3'b110; drv_lo = 3'b110;
        wait_clk(1);
        chk("R6 hiz_main", {31'd0, hiz_main}, 32'd1);
        chk("R9 irq gated off", {31'd0, irq}, 32'd0);
        rd(4, d); chk("R6 pair flags", d, 32'h0003_0103);

        // R9 pair interrupt enable
        phase = "R9";
        wr(2, 32'h0001_0000);
        wait_clk(1);
        chk("R9 irq from pairs", {31'd0, irq}, 32'd1);
        wr(4, 32'h0000_0103);
        wait_clk(1);
        chk("R10 pair clear", {30'd0, hiz_main, irq}, 32'b00);

        // R8 software force
        phase = "R8";
        wr(2, 32'h0002_0000);
        wait_clk(1);
        chk("R8 force main", {30'd0, hiz_main, hiz_ch0}, 32'b10);
        wr(2, 32'h0004_0000);
        wait_clk(1);
        chk("R8 force ch0", {30'd0, hiz_main, hiz_ch0}, 32'b01);
        wr(2, 32'h0);
        wait_clk(2);
        chk("R8 release", {30'd0, hiz_main, hiz_ch0}, 32'b00);

        finish_run();
    end
endmodule